// File: doc/BRIEF.md
# Integer Execute Unit with Overflow Trap

A purely combinational integer execute stage for a 32-bit RISC pipeline. Each operation takes two operands, an optional third operand (the destination value for a bitfield insert), an immediate shift count and a bitfield position and width. The unit returns a result word, a write-enable for the register write-back, an overflow-trap flag and a branch-condition flag.

The operation set covers wrapping and trapping add and subtract, the four shift kinds (left, right logical, right arithmetic, rotate right) by immediate or by register amount, leading-zero and leading-one counts, bitfield extract and insert, a byte swap inside each halfword, and sign extension of a byte or halfword. Ten compare conditions drive the branch flag. A trapping operation that overflows suppresses its write so the destination register keeps its old value.

Top module: `int_exec_unit`

## Requirements
- R1: Op 0 returns a+b and op 2 returns a−b, both modulo 2^32, with the overflow flag low and the write enable high.
- R2: Op 1 (trapping add) raises the overflow flag exactly when a and b share a sign bit and the sum's sign bit differs from it; with the flag set the write enable is low, otherwise the sum is written.
- R3: Op 3 (trapping subtract) raises the overflow flag exactly when a and b differ in sign bit and the difference's sign bit differs from a's; with the flag set the write enable is low. No other op raises the flag.
- R4: Ops 4..7 shift a by the immediate count: 4 left, 5 right logical, 6 right arithmetic, 7 rotate right, where rotate right by n is (a>>n)|(a<<(32−n)) and a rotate by 0 returns a.
- R5: Ops 8..11 perform the same four shifts in the same order with the count taken from b bits 4:0; b bits 31:5 have no effect on the result.
- R6: Op 12 returns the number of leading zero bits of a scanning from bit 31 down, op 13 the number of leading one bits; an all-zero (op 12) or all-one (op 13) input gives 32.
- R7: Op 14 returns (a >> pos) masked to its low `size` bits; a size of 32 or more keeps all bits.
- R8: Op 15 returns c with the bits under the mask ((1<<size)−1)<<pos replaced by the same bits of (a<<pos); all other bits of c pass through.
- R9: Op 16 exchanges the two bytes inside each 16-bit half of a.
- R10: Op 17 sign-extends a bits 7:0 and op 18 sign-extends a bits 15:0 to 32 bits.
- R11: Ops 19..28 set the branch flag for eq, ne, signed ge, unsigned ge, signed lt, unsigned lt, a≥0, a>0, a≤0, a<0 (signed) in that order; these ops return result 0 with the write enable low, and every other op leaves the branch flag low.
- R12: Op codes 29..31 return result 0 with write enable, overflow and branch flag all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; bits 4:0 are the register shift count |
| c_i | input | 32 | Destination value for bitfield insert |
| shamt_i | input | 5 | Immediate shift count |
| pos_i | input | 5 | Bitfield lowest bit position |
| size_i | input | 6 | Bitfield width |
| result_o | output | 32 | Result word |
| wr_en_o | output | 1 | Result write enable |
| ovf_o | output | 1 | Overflow trap |
| cond_o | output | 1 | Branch condition |

## Verification
The embedded assertions watch, on every evaluation, that an overflow never coexists with a write, that only the two trapping ops can flag overflow, that the branch flag only rises for compare ops, that counts stay within 0..32 and that an extract leaves no bits above its width. Exact result values, the precise overflow boundary, rotate-by-zero, the independence of register shifts from b's upper bits and bit preservation during insert are only shown by the bench's sweeps, which compare every op against arithmetic computed in the bench over edge operands, pseudo-random operands and every shift count and bitfield geometry.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,  OP_ADDV = 5'd1,  OP_SUB  = 5'd2,  OP_SUBV = 5'd3,
        OP_SLL  = 5'd4,  OP_SRL  = 5'd5,  OP_SRA  = 5'd6,  OP_ROR  = 5'd7,
        OP_SLLV = 5'd8,  OP_SRLV = 5'd9,  OP_SRAV = 5'd10, OP_RORV = 5'd11,
        OP_CLZ  = 5'd12, OP_CLO  = 5'd13, OP_EXT  = 5'd14, OP_INS  = 5'd15,
        OP_WSBH = 5'd16, OP_SEB  = 5'd17, OP_SEH  = 5'd18,
        OP_EQ   = 5'd19, OP_NE   = 5'd20, OP_GE   = 5'd21, OP_GEU  = 5'd22,
        OP_LT   = 5'd23, OP_LTU  = 5'd24, OP_GEZ  = 5'd25, OP_GTZ  = 5'd26,
        OP_LEZ  = 5'd27, OP_LTZ  = 5'd28
    } iexu_op_e;

    typedef enum logic [2:0] {
        GRP_ARITH, GRP_SHIFT, GRP_BITS, GRP_CMP, GRP_NONE
    } iexu_grp_e;

    function automatic iexu_grp_e op_group(input logic [4:0] op);
        if (op <= 5'd3)       return GRP_ARITH;
        else if (op <= 5'd11) return GRP_SHIFT;
        else if (op <= 5'd18) return GRP_BITS;
        else if (op <= 5'd28) return GRP_CMP;
        else                  return GRP_NONE;
    endfunction

    function automatic logic op_traps(input logic [4:0] op);
        return (op == OP_ADDV) || (op == OP_SUBV);
    endfunction

endpackage

// File: rtl/iexu_arith.sv
module iexu_arith
    import iexu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [4:0]      op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] res_o,
    output logic            ovf_o,
    output logic            cond_o
);
    localparam int MSB = XLEN - 1;

    logic [XLEN-1:0] sum, dif;
    logic            ovf_add, ovf_sub;

    assign sum = a_i + b_i;
    assign dif = a_i - b_i;

    // same-sign inputs, flipped sign out
    assign ovf_add = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);
    // opposite-sign inputs, result sign leaves the minuend's
    assign ovf_sub = (a_i[MSB] != b_i[MSB]) && (dif[MSB] != a_i[MSB]);

    always_comb begin
        res_o = '0;
        ovf_o = 1'b0;
        case (op_i)
            OP_ADD:  res_o = sum;
            OP_ADDV: begin res_o = sum; ovf_o = ovf_add; end
            OP_SUB:  res_o = dif;
            OP_SUBV: begin res_o = dif; ovf_o = ovf_sub; end
            default: ;
        endcase
    end

    always_comb begin
        cond_o = 1'b0;
        case (op_i)
            OP_EQ:  cond_o = (a_i == b_i);
            OP_NE:  cond_o = (a_i != b_i);
            OP_GE:  cond_o = ($signed(a_i) >= $signed(b_i));
            OP_GEU: cond_o = (a_i >= b_i);
            OP_LT:  cond_o = ($signed(a_i) < $signed(b_i));
            OP_LTU: cond_o = (a_i < b_i);
            OP_GEZ: cond_o = !a_i[MSB];
            OP_GTZ: cond_o = !a_i[MSB] && (|a_i);
            OP_LEZ: cond_o = a_i[MSB] || (a_i == '0);
            OP_LTZ: cond_o = a_i[MSB];
            default: ;
        endcase
    end
endmodule

// File: rtl/iexu_shift.sv
module iexu_shift
    import iexu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [4:0]      op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [SHW-1:0]  imm_amt_i,
    input  logic [SHW-1:0]  reg_amt_i,
    output logic [XLEN-1:0] res_o
);
    logic [SHW-1:0]  amt;
    logic [SHW:0]    back;
    logic [XLEN-1:0] rot;

    // register forms are codes 8..11: bit 3 selects the count source
    assign amt  = op_i[3] ? reg_amt_i : imm_amt_i;
    assign back = (SHW+1)'(XLEN) - {1'b0, amt};
    assign rot  = (amt == '0) ? a_i : ((a_i >> amt) | (a_i << back));

    always_comb begin
        unique case (op_i[1:0])
            2'd0: res_o = a_i << amt;
            2'd1: res_o = a_i >> amt;
            2'd2: res_o = $signed(a_i) >>> amt;
            default: res_o = rot;
        endcase
    end
endmodule

// File: rtl/iexu_bits.sv
module iexu_bits
    import iexu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int SHW  = $clog2(XLEN),
    parameter int CW   = $clog2(XLEN + 1)
) (
    input  logic [4:0]      op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] c_i,
    input  logic [SHW-1:0]  pos_i,
    input  logic [CW-1:0]   size_i,
    output logic [XLEN-1:0] res_o
);
    localparam int HALVES = XLEN / 16;

    function automatic logic [CW-1:0] lead_zeros(input logic [XLEN-1:0] v);
        logic [CW-1:0] n;
        logic          hit;
        n   = '0;
        hit = 1'b0;
        for (int i = XLEN - 1; i >= 0; i--) begin
            if (!hit) begin
                if (v[i]) hit = 1'b1;
                else      n   = n + 1'b1;
            end
        end
        return n;
    endfunction

    logic [XLEN-1:0] fmask, imask, ext_v, ins_v, swp_v, seb_v, seh_v;

    assign fmask = (size_i >= CW'(XLEN)) ? '1 : ((XLEN'(1) << size_i) - XLEN'(1));
    assign imask = fmask << pos_i;
    assign ext_v = (a_i >> pos_i) & fmask;
    assign ins_v = (c_i & ~imask) | ((a_i << pos_i) & imask);

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign swp_v[16*h +: 16] = {a_i[16*h +: 8], a_i[16*h+8 +: 8]};
    end

    assign seb_v = ((a_i & XLEN'(8'hFF))   ^ XLEN'(8'h80))    - XLEN'(8'h80);
    assign seh_v = ((a_i & XLEN'(16'hFFFF)) ^ XLEN'(16'h8000)) - XLEN'(16'h8000);

    always_comb begin
        case (op_i)
            OP_CLZ:  res_o = XLEN'(lead_zeros(a_i));
            OP_CLO:  res_o = XLEN'(lead_zeros(~a_i));
            OP_EXT:  res_o = ext_v;
            OP_INS:  res_o = ins_v;
            OP_WSBH: res_o = swp_v;
            OP_SEB:  res_o = seb_v;
            OP_SEH:  res_o = seh_v;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import iexu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [4:0]                   op_i,
    input  logic [XLEN-1:0]              a_i,
    input  logic [XLEN-1:0]              b_i,
    input  logic [XLEN-1:0]              c_i,
    input  logic [$clog2(XLEN)-1:0]      shamt_i,
    input  logic [$clog2(XLEN)-1:0]      pos_i,
    input  logic [$clog2(XLEN+1)-1:0]    size_i,
    output logic [XLEN-1:0]              result_o,
    output logic                         wr_en_o,
    output logic                         ovf_o,
    output logic                         cond_o
);
    localparam int SHW = $clog2(XLEN);
    localparam int CW  = $clog2(XLEN + 1);

    iexu_grp_e       grp;
    logic [XLEN-1:0] ar_res, sh_res, bt_res;
    logic            ar_ovf, ar_cond;

    assign grp = op_group(op_i);

    iexu_arith #(.XLEN(XLEN)) u_arith (
        .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .res_o(ar_res), .ovf_o(ar_ovf), .cond_o(ar_cond)
    );

    iexu_shift #(.XLEN(XLEN), .SHW(SHW)) u_shift (
        .op_i(op_i), .a_i(a_i), .imm_amt_i(shamt_i),
        .reg_amt_i(b_i[SHW-1:0]), .res_o(sh_res)
    );

    iexu_bits #(.XLEN(XLEN), .SHW(SHW), .CW(CW)) u_bits (
        .op_i(op_i), .a_i(a_i), .c_i(c_i), .pos_i(pos_i),
        .size_i(size_i), .res_o(bt_res)
    );

    always_comb begin
        unique case (grp)
            GRP_ARITH: result_o = ar_res;
            GRP_SHIFT: result_o = sh_res;
            GRP_BITS:  result_o = bt_res;
            default:   result_o = '0;
        endcase
        ovf_o   = (grp == GRP_ARITH) && ar_ovf;
        cond_o  = (grp == GRP_CMP) && ar_cond;
        wr_en_o = (grp == GRP_ARITH || grp == GRP_SHIFT || grp == GRP_BITS) && !ovf_o;
    end

    always_comb begin
        p_ovf_no_write_r2: assert (!(ovf_o && wr_en_o))
            else $error("overflow with write enable (R2)");
        p_ovf_source_r3: assert (!ovf_o || op_traps(op_i))
            else $error("overflow from non-trapping op (R3)");
        p_cond_compare_r11: assert (!cond_o || (op_group(op_i) == GRP_CMP))
            else $error("branch flag from non-compare op (R11)");
        p_count_bound_r6: assert (!(op_i == OP_CLZ || op_i == OP_CLO) || (result_o <= XLEN'(XLEN)))
            else $error("leading count out of range (R6)");
        p_ext_width_r7: assert (!(op_i == OP_EXT && size_i < CW'(XLEN)) || ((result_o >> size_i) == '0))
            else $error("extract wider than size (R7)");
    end
endmodule

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;
    logic        clk = 1'b0;
    logic [4:0]  op;
    logic [31:0] a, b, c;
    logic [4:0]  shamt, pos;
    logic [5:0]  size;
    logic [31:0] result;
    logic        wr_en, ovf, cond;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #4 clk = ~clk;

    int_exec_unit u0 (
        .op_i(op), .a_i(a), .b_i(b), .c_i(c), .shamt_i(shamt), .pos_i(pos),
        .size_i(size), .result_o(result), .wr_en_o(wr_en), .ovf_o(ovf), .cond_o(cond)
    );

    function automatic string tag(input int o);
        if (o == 0 || o == 2) return "R1";
        if (o == 1)  return "R2";
        if (o == 3)  return "R3";
        if (o <= 7)  return "R4";
        if (o <= 11) return "R5";
        if (o <= 13) return "R6";
        if (o == 14) return "R7";
        if (o == 15) return "R8";
        if (o == 16) return "R9";
        if (o <= 18) return "R10";
        if (o <= 28) return "R11";
        return "R12";
    endfunction

    function automatic int lead(input logic [31:0] v, input logic bitv);
        int n = 0;
        while (n < 32 && v[31-n] == bitv) n++;
        return n;
    endfunction

    // returns {result, wr_en, ovf, cond}
    function automatic logic [34:0] model(input int o, input logic [31:0] x, y, z,
                                          input int sh, ps, sz);
        longint sx = longint'($signed(x));
        longint sy = longint'($signed(y));
        longint wide;
        logic [63:0] dbl;
        logic [31:0] r = 0;
        logic w = 1, v = 0, k = 0;
        int n = (o >= 8) ? int'(y % 32) : sh;
        case (o)
            0: r = x + y;
            1: begin wide = sx + sy; r = 32'(wide);
                     v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
            2: r = x - y;
            3: begin wide = sx - sy; r = 32'(wide);
                     v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
            4, 8:  r = 32'(64'(x) * (64'd1 << n));
            5, 9:  r = x / (32'd1 << n);
            6, 10: begin wide = sx; for (int i = 0; i < n; i++) wide = (wide - ((wide % 2 + 2) % 2)) / 2; r = 32'(wide); end
            7, 11: begin dbl = {x, x}; r = 32'(dbl / (64'd1 << n)); end
            12: r = 32'(lead(x, 1'b0));
            13: r = 32'(lead(x, 1'b1));
            14: r = 32'((64'(x) / (64'd1 << ps)) % (64'd1 << (sz > 32 ? 32 : sz)));
            15: begin r = z; for (int i = 0; i < sz; i++) if (ps + i < 32) r[ps+i] = x[i]; end
            16: r = {x[23:16], x[31:24], x[7:0], x[15:8]};
            17: r = 32'(longint'($signed(x[7:0])));
            18: r = 32'(longint'($signed(x[15:0])));
            default: begin
                w = 0;
                case (o)
                    19: k = (x == y);
                    20: k = (x != y);
                    21: k = (sx >= sy);
                    22: k = ({1'b0, x} >= {1'b0, y});
                    23: k = (sx < sy);
                    24: k = ({1'b0, x} < {1'b0, y});
                    25: k = (sx >= 0);
                    26: k = (sx > 0);
                    27: k = (sx <= 0);
                    28: k = (sx < 0);
                    default: ;
                endcase
            end
        endcase
        if (v) w = 0;
        return {r, w, v, k};
    endfunction

    task automatic run(input int o, input logic [31:0] x, y, z, input int sh, ps, sz);
        logic [34:0] exp;
        @(posedge clk);
        op = 5'(o); a = x; b = y; c = z; shamt = 5'(sh); pos = 5'(ps); size = 6'(sz);
        @(negedge clk);
        exp = model(o, x, y, z, sh, ps, sz);
        checks++;
        if ({result, wr_en, ovf, cond} !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h c=%h sh=%0d pos=%0d size=%0d: got res=%h wr=%b ovf=%b cond=%b exp res=%h wr=%b ovf=%b cond=%b",
                     tag(o), o, x, y, z, sh, ps, sz, result, wr_en, ovf, cond,
                     exp[34:3], exp[2], exp[1], exp[0]);
        end
    endtask

    function automatic logic [31:0] step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    logic [31:0] edges [12] = '{32'h0, 32'h1, 32'h2, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
                                32'hFFFF_FFFE, 32'h8000_0001, 32'h1234_5678, 32'hF0F0_F0F0,
                                32'h0000_FFFF, 32'h0000_8080};

    initial begin
        while (cycles < 190000) begin @(posedge clk); cycles++; end
        errors++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // idle state: wrapping add of zeros (R1)
        run(0, 0, 0, 0, 0, 0, 32);
        // every op over all edge pairs: overflow limits R2 R3, compares R11, unused codes R12
        for (int o = 0; o < 32; o++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    run(o, edges[i], edges[j], edges[(i + j) % 12], j * 3 % 32, i, 32 - i);
        // pseudo-random operands for all ops
        for (int t = 0; t < 120; t++) begin
            logic [31:0] x, y, z;
            lfsr = step(lfsr); x = lfsr;
            lfsr = step(lfsr); y = lfsr;
            lfsr = step(lfsr); z = lfsr;
            for (int o = 0; o < 32; o++) run(o, x, y, z, int'(z[4:0]), int'(y[9:5]), int'(x[4:0]) + 1);
        end
        // every shift count, immediate R4 and register R5 with noisy b upper bits
        for (int i = 0; i < 12; i++)
            for (int n = 0; n < 32; n++)
                for (int o = 4; o < 12; o++) begin
                    lfsr = step(lfsr);
                    run(o, edges[i] ^ lfsr, {lfsr[31:5], 5'(n)}, 0, n, 0, 32);
                end
        // every bitfield geometry: extract R7 and insert R8
        for (int p = 0; p < 32; p++)
            for (int s = 1; s <= 32 - p; s++) begin
                lfsr = step(lfsr);
                run(14, lfsr, 0, 0, 0, p, s);
                run(15, lfsr, 0, ~lfsr, 0, p, s);
            end
        // single-bit sweeps for counts R6, swap R9, sign extension R10
        for (int k = 0; k < 32; k++) begin
            run(12, 32'h1 << k, 0, 0, 0, 0, 32);
            run(13, ~(32'h1 << k), 0, 0, 0, 0, 32);
            run(16, 32'h1 << k, 0, 0, 0, 0, 32);
            run(17, 32'h1 << k, 0, 0, 0, 0, 32);
            run(18, 32'h1 << k, 0, 0, 0, 0, 32);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule